// File: doc/BRIEF.md
# Bitwise Three-Input Lookup Unit

This execution unit evaluates an arbitrary three-input boolean function across a 64-bit word. For each bit position it takes one bit from the old destination value and one bit from each of two sources. Those three bits form a 3-bit index, and the index picks one entry of an 8-entry truth table held in the low byte of a fourth operand. The result replaces the destination register, so the destination value is both an input and the output. Every bit position is computed on its own.

The unit also decodes the 32-bit instruction word. It returns the four register numbers, so that the surrounding pipeline can read operands and write back the result. A 2-bit selector can swap the roles of the destination and second source inside the index. If the record bit is set, the unit writes a 4-bit condition field that compares the signed result with zero. A word that does not carry this operation's opcode gets no valid result: the unit raises an illegal flag and passes the old destination value through unchanged. A parameter chooses between a purely combinational path and one output register stage. The default is the register stage.

Top module: `bitlut_exec`

## Requirements
- R1: Instruction bits are numbered with `insn[31]` as the most significant. `fld_rt` is `insn[25:21]`, `fld_ra` is `insn[20:16]`, `fld_rb` is `insn[15:11]` and `fld_rc` is `insn[10:6]`. These fields are reported for every word, legal or not.
- R2: With selector `insn[5:4]` = 00, result bit i equals `rc_val[idx]`, where idx = {rt_old[i], ra_val[i], rb_val[i]} and rt_old is the most significant bit.
- R3: With selector 01, the order is reversed: idx = {rb_val[i], ra_val[i], rt_old[i]}, so rb_val is the most significant bit.
- R4: Selector values 10 and 11 are reserved and give the same result as selector 00.
- R5: Bits 63:8 of `rc_val` have no effect on any output.
- R6: A word is recognised when `insn[31:26]` equals the parameter OPCODE (default 5) and `insn[3:1]` = 010. A recognised word gives `res_valid`=1 and `illegal`=0. Any other word gives `res_valid`=0, `illegal`=1 and `res` = `rt_old`.
- R7: `cr_we` = 1 exactly when the word is recognised and `insn[0]` = 1. In that case `cr[3]` means less than, `cr[2]` greater than, `cr[1]` equal and `cr[0]` summary overflow, which is always 0. Each of the first three compares the signed 64-bit result with zero. When `cr_we` = 0, `cr` = 0.
- R8: With REG_OUT=1, every output shows the response to the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Instruction word |
| rt_old | input | 64 | Old destination value (most significant index input) |
| ra_val | input | 64 | First source value |
| rb_val | input | 64 | Second source value |
| rc_val | input | 64 | Truth-table operand; only bits 7:0 are used |
| fld_rt | output | 5 | Destination register number |
| fld_ra | output | 5 | First source register number |
| fld_rb | output | 5 | Second source register number |
| fld_rc | output | 5 | Table register number |
| res | output | 64 | Result to write back to the destination |
| res_valid | output | 1 | Word recognised, result valid |
| illegal | output | 1 | Word not recognised |
| cr_we | output | 1 | Condition field is to be written |
| cr | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
The eight table positions are each driven with operands that put the same index in every bit. A one-hot table must then give all ones, and its complement must give all zeros. This exposes any swapped or stuck index bit, and it runs under both orderings, where the swap moves positions 1↔4 and 3↔6. Random operands with random tables, selectors and record bits, some with garbage in the upper table bits, separate the reserved selectors from the reversed one and show that the upper table bits are unused. Words with a wrong opcode or a wrong low mode field separate recognition from pass-through. Directed results that are zero, negative and positive select each of the condition bits in turn.

// File: rtl/bitlut_pkg.sv
package bitlut_pkg;

    localparam int INSN_W = 32;
    localparam int REG_W  = 5;
    localparam int TBL_N  = 8;
    localparam int CR_W   = 4;

    localparam logic [2:0] XO_LOOKUP = 3'b010;

    typedef enum logic [1:0] {
        ORD_NORMAL = 2'b00,
        ORD_SWAP   = 2'b01,
        ORD_RSV_A  = 2'b10,
        ORD_RSV_B  = 2'b11
    } order_e;

    typedef struct packed {
        logic [5:0]       opcd;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rc;
        order_e           ord;
        logic [2:0]       xo;
        logic             rec;
    } insn_t;

    typedef struct packed {
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rc;
    } regs_t;

    // Index formation: reserved orderings fall back to the normal one.
    function automatic logic [2:0] lut_index(order_e o, logic t, logic a, logic b);
        return (o == ORD_SWAP) ? {b, a, t} : {t, a, b};
    endfunction

endpackage

// File: rtl/bitlut_decode.sv
module bitlut_decode
    import bitlut_pkg::*;
#(
    parameter logic [5:0] OPCODE = 6'd5
) (
    input  logic [INSN_W-1:0] insn,
    output insn_t             fld,
    output logic              legal
);
    always_comb begin
        fld.opcd = insn[31:26];
        fld.rt   = insn[25:21];
        fld.ra   = insn[20:16];
        fld.rb   = insn[15:11];
        fld.rc   = insn[10:6];
        fld.ord  = order_e'(insn[5:4]);
        fld.xo   = insn[3:1];
        fld.rec  = insn[0];
    end

    assign legal = (fld.opcd == OPCODE) && (fld.xo == XO_LOOKUP);
endmodule

// File: rtl/bitlut_array.sv
module bitlut_array
    import bitlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  order_e            ord,
    input  logic [XLEN-1:0]   t_in,
    input  logic [XLEN-1:0]   a_in,
    input  logic [XLEN-1:0]   b_in,
    input  logic [TBL_N-1:0]  tbl,
    output logic [XLEN-1:0]   y
);
    for (genvar g = 0; g < XLEN; g++) begin : g_bit
        logic [2:0] idx;
        assign idx  = lut_index(ord, t_in[g], a_in[g], b_in[g]);
        assign y[g] = tbl[idx];
    end
endmodule

// File: rtl/bitlut_flags.sv
module bitlut_flags
    import bitlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val,
    input  logic            en,
    output logic            we,
    output logic [CR_W-1:0] cr
);
    logic neg, zero, pos;

    assign neg  = val[XLEN-1];
    assign zero = (val == '0);
    assign pos  = !neg && !zero;
    assign we   = en;
    assign cr   = en ? {neg, pos, zero, 1'b0} : '0;
endmodule

// File: rtl/bitlut_outreg.sv
module bitlut_outreg #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/bitlut_exec.sv
module bitlut_exec
    import bitlut_pkg::*;
#(
    parameter int         XLEN    = 64,
    parameter logic [5:0] OPCODE  = 6'd5,
    parameter bit         REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   rt_old,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [XLEN-1:0]   rc_val,
    output logic [4:0]        fld_rt,
    output logic [4:0]        fld_ra,
    output logic [4:0]        fld_rb,
    output logic [4:0]        fld_rc,
    output logic [XLEN-1:0]   res,
    output logic              res_valid,
    output logic              illegal,
    output logic              cr_we,
    output logic [3:0]        cr
);
    localparam int REGS_W = $bits(regs_t);
    localparam int OUT_W  = XLEN + 3 + CR_W + REGS_W;

    insn_t            dec;
    logic             legal;
    logic [XLEN-1:0]  lut_y;
    logic [XLEN-1:0]  sel_y;
    logic             f_we;
    logic [CR_W-1:0]  f_cr;
    regs_t            regs_d, regs_q;
    logic [OUT_W-1:0] pack_d, pack_q;
    logic             unused_tbl_hi;

    assign unused_tbl_hi = ^rc_val[XLEN-1:TBL_N];

    bitlut_decode #(.OPCODE(OPCODE)) u_dec (
        .insn  (insn),
        .fld   (dec),
        .legal (legal)
    );

    bitlut_array #(.XLEN(XLEN)) u_arr (
        .ord  (dec.ord),
        .t_in (rt_old),
        .a_in (ra_val),
        .b_in (rb_val),
        .tbl  (rc_val[TBL_N-1:0]),
        .y    (lut_y)
    );

    assign sel_y = legal ? lut_y : rt_old;

    bitlut_flags #(.XLEN(XLEN)) u_flg (
        .val (sel_y),
        .en  (legal && dec.rec),
        .we  (f_we),
        .cr  (f_cr)
    );

    assign regs_d = '{rt: dec.rt, ra: dec.ra, rb: dec.rb, rc: dec.rc};
    assign pack_d = {sel_y, legal, !legal, f_we, f_cr, regs_d};

    bitlut_outreg #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (pack_d),
        .q   (pack_q)
    );

    assign {res, res_valid, illegal, cr_we, cr, regs_q} = pack_q;
    assign fld_rt = regs_q.rt;
    assign fld_ra = regs_q.ra;
    assign fld_rb = regs_q.rb;
    assign fld_rc = regs_q.rc;
endmodule

// File: rtl/bitlut_chk.sv
module bitlut_chk #(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] rt_old,
    input logic [7:0]      tbl,
    input logic [XLEN-1:0] res,
    input logic            res_valid,
    input logic            illegal,
    input logic            cr_we,
    input logic [3:0]      cr
);
    if (REG_OUT) begin : g_seq
        // R6: valid and illegal never both set
        a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(res_valid && illegal));
        // R6: unrecognised word passes old destination through
        a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
            illegal |-> res == $past(rt_old));
        // R7: condition field is zero unless written
        a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
            !cr_we |-> cr == 4'b0000);
        // R7: summary overflow bit stays clear
        a_r7_so_zero: assert property (@(posedge clk) disable iff (rst)
            cr[0] == 1'b0);
        // R7: exactly one relation reported
        a_r7_one_rel: assert property (@(posedge clk) disable iff (rst)
            cr_we |-> $countones(cr[3:1]) == 1);
        // R7: equal flag tracks a zero result
        a_r7_eq_zero: assert property (@(posedge clk) disable iff (rst)
            cr_we |-> cr[1] == (res == '0));
        // R2: all-ones table yields all-ones result
        a_r2_tbl_ones: assert property (@(posedge clk) disable iff (rst)
            (res_valid && $past(tbl) == 8'hFF) |-> res == '1);
        // R2: all-zeros table yields zero result
        a_r2_tbl_zero: assert property (@(posedge clk) disable iff (rst)
            (res_valid && $past(tbl) == 8'h00) |-> res == '0);
    end else begin : g_comb
        always_comb begin
            if (!rst) begin
                a_r6_exclusive: assert (!(res_valid && illegal));
                a_r6_passthru:  assert (!illegal || res == rt_old);
                a_r7_quiet:     assert (cr_we || cr == 4'b0000);
                a_r7_so_zero:   assert (cr[0] == 1'b0);
                a_r2_tbl_ones:  assert (!(res_valid && tbl == 8'hFF) || res == '1);
            end
        end
    end
endmodule

bind bitlut_exec bitlut_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rt_old    (rt_old),
    .tbl       (rc_val[7:0]),
    .res       (res),
    .res_valid (res_valid),
    .illegal   (illegal),
    .cr_we     (cr_we),
    .cr        (cr)
);

// File: tb/sim_bitlut_exec.sv
`timescale 1ns/1ps
module sim_bitlut_exec;
    localparam logic [5:0] OPC = 6'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = '0;
    logic [63:0] rt_old = '0, ra_val = '0, rb_val = '0, rc_val = '0;
    logic [4:0]  fld_rt, fld_ra, fld_rb, fld_rc;
    logic [63:0] res;
    logic        res_valid, illegal, cr_we;
    logic [3:0]  cr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bitlut_exec #(.XLEN(64), .OPCODE(OPC), .REG_OUT(1'b1)) u0 (.*);

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] t, logic [4:0] a,
                                       logic [4:0] b, logic [4:0] c, logic [1:0] sel,
                                       logic [2:0] xo, logic rec);
        return {op, t, a, b, c, sel, xo, rec};
    endfunction

    function automatic logic [63:0] model(logic [1:0] sel, logic [63:0] t, logic [63:0] a,
                                          logic [63:0] b, logic [63:0] c);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            logic [2:0] k;
            k = (sel == 2'b01) ? {b[i], a[i], t[i]} : {t[i], a[i], b[i]};
            r[i] = c[k];
        end
        return r;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
    task automatic apply(logic [31:0] w, logic [63:0] t, logic [63:0] a, logic [63:0] b,
                         logic [63:0] c, string req);
        logic        lg, we;
        logic [63:0] er;
        logic [3:0]  ec;
        insn = w; rt_old = t; ra_val = a; rb_val = b; rc_val = c;
        lg = (w[31:26] == OPC) && (w[3:1] == 3'b010);
        er = lg ? model(w[5:4], t, a, b, c) : t;
        we = lg && w[0];
        ec = we ? {er[63], !er[63] && (er != 0), er == 0, 1'b0} : 4'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req, "res", res, er);
        chk("R6", "valid/illegal", {62'b0, res_valid, illegal}, {62'b0, lg, !lg});
        chk("R7", "cr_we/cr", {59'b0, cr_we, cr}, {59'b0, we, ec});
        chk("R1", "fields", {44'b0, fld_rt, fld_ra, fld_rb, fld_rc}, {44'b0, w[25:6]});
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R8: reset clears outputs
        chk("R8", "reset outputs",
            {res[62:0] | {63{res[63]}}, res_valid | illegal | cr_we},
            64'b0);
        chk("R8", "reset cr/fields", {39'b0, cr, fld_rt, fld_ra, fld_rb, fld_rc}, 64'b0);
        rst = 1'b0;

        // R2: each table position under normal ordering
        for (int k = 0; k < 8; k++) begin
            logic [63:0] t, a, b;
            t = {64{k[2]}}; a = {64{k[1]}}; b = {64{k[0]}};
            apply(mk(OPC, 5'd1, 5'd2, 5'd3, 5'd4, 2'b00, 3'b010, 1'b0), t, a, b,
                  64'd1 << k, "R2");
            chk("R2", "one-hot table", res, '1);
            apply(mk(OPC, 5'd1, 5'd2, 5'd3, 5'd4, 2'b00, 3'b010, 1'b0), t, a, b,
                  ~(64'd1 << k), "R2");
        end

        // R3: reversed ordering, rt_old becomes least significant
        for (int k = 0; k < 8; k++) begin
            logic [63:0] t, a, b;
            t = {64{k[0]}}; a = {64{k[1]}}; b = {64{k[2]}};
            apply(mk(OPC, 5'd7, 5'd8, 5'd9, 5'd10, 2'b01, 3'b010, 1'b1), t, a, b,
                  64'd1 << k, "R3");
            chk("R3", "reversed one-hot", res, '1);
        end

        // R8: output holds until the next rising edge
        insn = mk(OPC, 5'd0, 5'd0, 5'd0, 5'd0, 2'b00, 3'b010, 1'b0);
        rc_val = 64'h0; #1;
        chk("R8", "hold before edge", res, '1);

        // R7: zero, negative and positive results
        apply(mk(OPC, 5'd3, 5'd3, 5'd3, 5'd3, 2'b00, 3'b010, 1'b1), r64(), r64(), r64(),
              64'h00, "R7");
        apply(mk(OPC, 5'd3, 5'd3, 5'd3, 5'd3, 2'b00, 3'b010, 1'b1), r64(), r64(), r64(),
              64'hFF, "R7");
        apply(mk(OPC, 5'd3, 5'd3, 5'd3, 5'd3, 2'b00, 3'b010, 1'b1), 64'h7FFF_0000_1234_5678,
              64'h0, 64'h0, 64'h10, "R7");

        // R6: wrong opcode and wrong low mode field
        apply(mk(6'd6, 5'd1, 5'd2, 5'd3, 5'd4, 2'b00, 3'b010, 1'b1), r64(), r64(), r64(),
              r64(), "R6");
        apply(mk(OPC, 5'd1, 5'd2, 5'd3, 5'd4, 2'b00, 3'b110, 1'b1), r64(), r64(), r64(),
              r64(), "R6");

        // Random mix across selectors, record bits and table garbage
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  sel;
            logic [5:0]  op;
            logic [2:0]  xo;
            logic [63:0] c;
            string       tag;
            sel = 2'($urandom);
            op  = ($urandom % 8 == 0) ? 6'($urandom) : OPC;
            xo  = ($urandom % 8 == 0) ? 3'($urandom) : 3'b010;
            c   = ($urandom % 2) ? r64() : {56'b0, 8'($urandom)};
            tag = (op != OPC || xo != 3'b010) ? "R6" :
                  (c[63:8] != 0) ? "R5" :
                  (sel == 2'b01) ? "R3" : (sel == 2'b00) ? "R2" : "R4";
            apply(mk(op, 5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), sel, xo,
                     1'($urandom)), r64(), r64(), r64(), c, tag);
        end

        // R4: reserved selectors match normal ordering on the same operands
        for (int s = 2; s < 4; s++) begin
            logic [63:0] t, a, b, c;
            t = r64(); a = r64(); b = r64(); c = {56'b0, 8'($urandom)};
            apply(mk(OPC, 5'd1, 5'd1, 5'd1, 5'd1, 2'(s), 3'b010, 1'b0), t, a, b, c, "R4");
            chk("R4", "reserved vs normal", res, model(2'b00, t, a, b, c));
        end

        // R5: upper table bits ignored
        begin
            logic [63:0] t, a, b;
            t = r64(); a = r64(); b = r64();
            apply(mk(OPC, 5'd2, 5'd2, 5'd2, 5'd2, 2'b00, 3'b010, 1'b1), t, a, b,
                  64'hDEAD_BEEF_CAFE_F0A5, "R5");
            chk("R5", "upper table bits", res, model(2'b00, t, a, b, 64'hA5));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule